// File: doc/BRIEF.md
# Serial Port Register and FIFO Front End

This block is the register side of a synchronous serial port. A simple read/write bus reaches four registers through a two-bit address. The data register is a single address: a write appends a word to the transmit queue and a read takes the oldest word from the receive queue. The status register reports queue fill and engine activity. The prescale register holds an even clock divisor. The size register selects the word length.

The serial shift engine sits on the far side of the block. It drains the transmit queue with a pop strobe, fills the receive queue with a push strobe, and reports activity on a busy input. The block sends the engine a one-cycle clock enable at the programmed rate and the effective word length. Words entering either queue are masked to that length. Received words therefore come back right-justified, with zeros above the word length.

Top module: `ssp_regfront`

## Requirements
- R1: A bus write to address 0 pushes `bus_wdata` into an 8-entry transmit FIFO. `tx_valid` is 1 whenever that FIFO holds a word, `tx_data` shows the oldest word, and each `tx_pop` advances to the next word in write order.
- R2: A pushed transmit word has every bit above the effective word length forced to zero.
- R3: A write to address 0 while the transmit FIFO holds 8 words, with no `tx_pop` in the same cycle, is dropped.
- R4: A bus read of address 0 pops the 8-entry receive FIFO. Received words are masked to the effective word length when pushed. A read of an empty receive FIFO returns zero and changes nothing.
- R5: An `rx_push` while the receive FIFO holds 8 words and no read pops it in the same cycle is dropped.
- R6: A read of address 1 returns the status word: bit0 = transmit FIFO empty, bit1 = transmit FIFO not full, bit2 = receive FIFO not empty, bit3 = receive FIFO full, bit4 = `eng_busy`, bits 15:5 = 0. Every read returns its value on `bus_rdata` in the cycle after `bus_rd`.
- R7: The status flags reflect a push or pop starting from the cycle after it.
- R8: A push and a pop in the same cycle on a FIFO that holds at least one word leave its count unchanged. This also holds when the FIFO is full, in which case the pushed word is kept.
- R9: Address 2 is the prescale register. It resets to 2, and bit 0 always reads 0 whatever value is written.
- R10: `tick_en` is a one-cycle pulse that repeats every N clocks, where N is the stored prescale value. A stored 0 acts as N = 2.
- R11: Address 3 is a 4-bit size field that resets to 15 and reads back as written. The effective word length is the field value plus 1, where field values below 3 act as 3. `frame_bits` outputs the effective field value.
- R12: Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 prescale, 3 size |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| eng_busy | input | 1 | Engine is moving a frame |
| tick_en | output | 1 | Prescaled clock enable pulse |
| frame_bits | output | 4 | Effective word length minus 1 |
| tx_valid | output | 1 | Transmit FIFO holds a word |
| tx_data | output | 16 | Oldest transmit word |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_data | input | 16 | Received word |

## Verification
The bench sweeps every prescale byte from 0 to 255 and measures the pulse spacing. A design that honoured the odd bit, or stalled on zero, would show a wrong period or no pulses at all. It sweeps all sixteen size codes, which catches a mask that is off by one bit or that ignores the clamp below 3. It fills each FIFO past capacity and then drains it, which exposes an overwrite of the oldest word or a count that wraps to empty. It also pushes and pops in the same cycle on a full queue, where a design that checks full before the pop would lose the new word.

// File: rtl/ssp_regfront_pkg.sv
package ssp_regfront_pkg;
  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_STAT  = 2'd1,
    REG_PRESC = 2'd2,
    REG_SIZE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push)
        wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)
        rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_presc.sv
module ssp_presc #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [PRESC_W-1:0] wdata,
  output logic [PRESC_W-1:0] value,
  output logic               tick
);
  logic [PRESC_W-1:0] div_q;
  logic [PRESC_W-1:0] divisor;
  logic [PRESC_W-1:0] cnt;

  assign value   = div_q;
  assign divisor = (div_q == '0) ? PRESC_W'(2) : div_q;

  always_ff @(posedge clk) begin
    if (rst)     div_q <= PRESC_W'(2);
    else if (wr) div_q <= {wdata[PRESC_W-1:1], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ssp_regfront.sv
module ssp_regfront
  import ssp_regfront_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int PRESC_W    = 8,
  parameter int SIZE_W     = 4,
  parameter int MIN_SIZE   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  output logic              tick_en,
  output logic [SIZE_W-1:0] frame_bits,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int STAT_W = 5;

  logic [SIZE_W-1:0] size_q, eff_size;
  logic [DATA_W-1:0] word_mask, rx_head;
  logic [PRESC_W-1:0] presc_val;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic wr_data, wr_presc, wr_size, rd_data;

  assign wr_data  = bus_wr && (bus_addr == REG_DATA);
  assign wr_presc = bus_wr && (bus_addr == REG_PRESC);
  assign wr_size  = bus_wr && (bus_addr == REG_SIZE);
  assign rd_data  = bus_rd && (bus_addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst)          size_q <= '1;
    else if (wr_size) size_q <= bus_wdata[SIZE_W-1:0];
  end

  assign eff_size   = (size_q < SIZE_W'(MIN_SIZE)) ? SIZE_W'(MIN_SIZE) : size_q;
  assign frame_bits = eff_size;

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      word_mask[i] = (i <= int'(eff_size));
  end

  ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(wr_data), .din(bus_wdata & word_mask),
    .pop(tx_pop), .dout(tx_data),
    .empty(tx_empty), .full(tx_full)
  );

  ssp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_push), .din(rx_data & word_mask),
    .pop(rd_data), .dout(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  assign tx_valid = !tx_empty;

  ssp_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst),
    .wr(wr_presc), .wdata(bus_wdata[PRESC_W-1:0]),
    .value(presc_val), .tick(tick_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (reg_sel_e'(bus_addr))
        REG_DATA:  bus_rdata <= rx_empty ? '0 : rx_head;
        REG_STAT:  bus_rdata <= {{(DATA_W-STAT_W){1'b0}}, eng_busy, rx_full,
                                 !rx_empty, !tx_full, tx_empty};
        REG_PRESC: bus_rdata <= {{(DATA_W-PRESC_W){1'b0}}, presc_val};
        default:   bus_rdata <= {{(DATA_W-SIZE_W){1'b0}}, size_q};
      endcase
    end
  end
endmodule

// File: rtl/ssp_regfront_chk.sv
module ssp_regfront_chk
  import ssp_regfront_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              tick_en,
  input logic              tx_valid,
  input logic              rx_empty
);
  a_r10_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> !tick_en);

  a_r6_stat_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_STAT) |=> (bus_rdata[DATA_W-1:5] == '0));

  a_r9_presc_even: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_PRESC) |=> !bus_rdata[0]);

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == REG_DATA && rx_empty) |=> (bus_rdata == '0));

  a_r1_push_makes_valid: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_DATA && !tx_valid) |=> tx_valid);
endmodule

bind ssp_regfront ssp_regfront_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tick_en(tick_en),
  .tx_valid(tx_valid), .rx_empty(rx_empty)
);

// File: tb/sim_ssp_regfront.sv
module sim_ssp_regfront;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic eng_busy = 1'b0;
  logic tick_en;
  logic [3:0] frame_bits;
  logic tx_valid;
  logic [15:0] tx_data;
  logic tx_pop = 1'b0, rx_push = 1'b0;
  logic [15:0] rx_data = 16'h0;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssp_regfront u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .tick_en(tick_en), .frame_bits(frame_bits),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rxp(input logic [15:0] d);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic txpop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  function automatic logic [15:0] mask_of(input int s);
    int e = (s < 3) ? 3 : s;
    return 16'((32'h1 << (e + 1)) - 1);
  endfunction

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R1 reset tx_valid", {15'h0, tx_valid}, 16'h0);
    rd(2'd1, v); chk("R6 reset status", v, 16'h0003);
    rd(2'd2, v); chk("R9 reset prescale", v, 16'h0002);
    rd(2'd3, v); chk("R11 reset size", v, 16'h000F);
    chk("R11 reset frame_bits", {12'h0, frame_bits}, 16'h000F);

    // R12 status write ignored
    wr(2'd1, 16'hFFFF);
    rd(2'd1, v); chk("R12 status write ignored", v, 16'h0003);

    // R3: overfill the transmit FIFO
    for (int i = 0; i < 10; i++) wr(2'd0, 16'h1000 + 16'(i));
    rd(2'd1, v); chk("R6 R7 tx full status", v, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      chk("R1 R3 tx order", tx_data, 16'h1000 + 16'(i));
      chk("R1 tx_valid", {15'h0, tx_valid}, 16'h1);
      txpop();
    end
    chk("R3 tx drained", {15'h0, tx_valid}, 16'h0);

    // R8: simultaneous push and pop on a full transmit FIFO
    for (int i = 0; i < 8; i++) wr(2'd0, 16'h0100 + 16'(i));
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h01FF; tx_pop = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tx_pop = 1'b0;
    rd(2'd1, v); chk("R8 still full", v, 16'h0000);
    for (int i = 1; i < 9; i++) begin
      chk("R8 order after push+pop", tx_data, (i == 8) ? 16'h01FF : 16'h0100 + 16'(i));
      txpop();
    end
    chk("R8 empty after drain", {15'h0, tx_valid}, 16'h0);

    // R8: push and pop with one entry held
    wr(2'd0, 16'h0AAA);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0BBB; tx_pop = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tx_pop = 1'b0;
    chk("R8 single head", tx_data, 16'h0BBB);
    txpop();
    chk("R8 single drained", {15'h0, tx_valid}, 16'h0);

    // R2 R11: sweep all size codes
    for (int s = 0; s < 16; s++) begin
      wr(2'd3, 16'hFFF0 | 16'(s));
      rd(2'd3, v); chk("R11 size readback", v, 16'(s));
      chk("R11 frame_bits", {12'h0, frame_bits}, 16'((s < 3) ? 3 : s));
      wr(2'd0, 16'hBEEF);
      chk("R2 tx mask", tx_data, 16'hBEEF & mask_of(s));
      txpop();
    end

    // R4 R5: receive FIFO overfill at full width
    wr(2'd3, 16'h000F);
    for (int i = 0; i < 9; i++) rxp(16'hC000 + 16'(i));
    rd(2'd1, v); chk("R6 R7 rx full status", v, 16'h000F);
    for (int i = 0; i < 8; i++) begin
      rd(2'd0, v); chk("R4 R5 rx order", v, 16'hC000 + 16'(i));
    end
    rd(2'd0, v); chk("R4 empty read zero", v, 16'h0000);
    rd(2'd1, v); chk("R7 rx empty status", v, 16'h0003);
    rxp(16'h1234);
    rd(2'd0, v); chk("R4 pointers kept after empty read", v, 16'h1234);

    // R4 right-justify with 8-bit words
    wr(2'd3, 16'h0007);
    rxp(16'hABCD);
    rd(2'd0, v); chk("R4 rx mask", v, 16'h00CD);
    wr(2'd3, 16'h000F);

    // R6 busy bit
    eng_busy = 1'b1;
    rd(2'd1, v); chk("R6 busy bit", v, 16'h0013);
    eng_busy = 1'b0;

    // R9 R10: sweep every prescale byte
    for (int p = 0; p < 256; p++) begin
      int n, e;
      wr(2'd2, 16'(p));
      rd(2'd2, v); chk("R9 prescale readback", v, 16'(p & 8'hFE));
      e = ((p & 8'hFE) == 0) ? 2 : (p & 8'hFE);
      for (int k = 0; k < 2; k++) begin
        while (!tick_en) @(negedge clk);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick_en);
      end
      chk("R10 tick period", 16'(n), 16'(e));
    end

    finish_run();
  end
endmodule